// File: doc/BRIEF.md
# Shared-Vector Interrupt Flag Controller

This block keeps the interrupt request flags of several peripherals and turns them into vectored call requests for a processor core. Related flags are grouped, and each group drives one shared vector: the vector is requested while any flag of its group is set. Each flag is set by a one-cycle hardware event. Software can also set or clear any flag through a masked write port, and a write has the same effect as the hardware would. When a vector is taken, the flags are left unchanged. The service routine reads the flags, finds the sources that need service and clears them itself.

Vector requests are registered from the flags on one clock edge and arbitrated in the following cycle. A per-vector enable and a global enable gate the requests, and a fixed priority picks the lowest vector address. The winner is issued as a one-cycle call strobe together with a 16-bit vector address. No further call is issued until the core pulses the return acknowledge.

Top module: `shv_irq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `flags_q` is all zero and `call_req` is 0.
- R2: Hardware never clears a flag, including when its vector is taken. Only a software write lowers a flag bit.
- R3: When `sw_wr_en` is high, each flag bit whose `sw_wr_mask` bit is 1 takes the matching `sw_wr_data` bit at the next edge. Flag bits with a mask bit of 0 keep their value.
- R4: If `hw_evt[i]` is high, flag i is 1 after the next edge, even when a software write clears that bit in the same cycle.
- R5: The flags map onto vectors by index. Flags 0 and 1 drive vector 0. Flag 2 drives vector 1. Flags 3, 4 and 5 drive vector 2. Flags 6 and 7 drive vector 3. Flag 8 drives vector 4. A vector is pending while any of its flags is 1.
- R6: If a flag is set by edge k and its vector is the one granted, `call_req` is 0 after edge k+1 and is 1 after edge k+2.
- R7: A pending vector is issued only while its `vec_en` bit and `glb_en` are both 1. While it is disabled, its flags stay set.
- R8: When several eligible vectors are pending in the same cycle, the one with the lowest index, which is also the lowest address, wins.
- R9: `call_req` is high for exactly one cycle. While it is high, `call_addr` carries the address of the granted vector: 0x002B, 0x0033, 0x003B, 0x0043 or 0x004B for vectors 0 to 4.
- R10: After a call is issued, no further call is issued until `reti_ack` is seen. If vectors are still pending when `reti_ack` arrives at edge b, the next call appears after edge b+1.
- R11: If software clears a flag while its vector is disabled, and the vector is enabled later, that flag causes no call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_evt | input | 9 | One-cycle set events, one per flag |
| sw_wr_en | input | 1 | Software flag write strobe |
| sw_wr_mask | input | 9 | Selects the flag bits that the write changes |
| sw_wr_data | input | 9 | Values written to the selected flag bits |
| vec_en | input | 5 | Enable for each vector |
| glb_en | input | 1 | Global interrupt enable |
| reti_ack | input | 1 | Pulse from the core when the service routine returns |
| flags_q | output | 9 | Current flag register |
| call_req | output | 1 | One-cycle vectored call strobe |
| call_addr | output | 16 | Address of the vector being called |

## Verification
The bench builds the block with its fixed configuration of nine flags on five vectors. That configuration is small enough to sweep every one of the 32 pending-vector patterns against every one of the 32 per-vector enable masks. A further pass sweeps all patterns with the global enable off. In each trial the pending flag is rotated through the members of its group, so every flag-to-vector mapping is exercised. Directed sequences then cover the return-acknowledge hold, the clash between a hardware set and a software clear, the masked write, and the cancellation of a pending request by software.

// File: rtl/shv_irq_pkg.sv
package shv_irq_pkg;

    localparam int unsigned NUM_FLAG  = 9;
    localparam int unsigned NUM_VEC   = 5;
    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned VEC_BASE  = 16'h002B;
    localparam int unsigned VEC_STEP  = 8;

    typedef logic [NUM_FLAG-1:0] flag_vec_t;
    typedef logic [NUM_VEC-1:0]  vec_set_t;
    typedef logic [ADDR_W-1:0]   vec_addr_t;

    typedef struct packed {
        logic      valid;
        vec_addr_t addr;
    } call_t;

    // flag index -> shared vector index
    function automatic int unsigned vec_of_flag(int unsigned f);
        case (f)
            0, 1:    return 0;
            2:       return 1;
            3, 4, 5: return 2;
            6, 7:    return 3;
            default: return 4;
        endcase
    endfunction

    function automatic flag_vec_t group_mask(int unsigned v);
        flag_vec_t m;
        for (int unsigned f = 0; f < NUM_FLAG; f++)
            m[f] = (vec_of_flag(f) == v);
        return m;
    endfunction

    function automatic vec_addr_t vec_addr(int unsigned v);
        return vec_addr_t'(VEC_BASE + VEC_STEP * v);
    endfunction

endpackage

// File: rtl/shv_flag_bank.sv
module shv_flag_bank
    import shv_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t hw_evt,
    input  logic      wr_en,
    input  flag_vec_t wr_mask,
    input  flag_vec_t wr_data,
    output flag_vec_t flags
);

    flag_vec_t sw_next;

    always_comb begin
        sw_next = flags;
        if (wr_en)
            sw_next = (flags & ~wr_mask) | (wr_data & wr_mask);
    end

    // hardware set has priority over any software clear
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= sw_next | hw_evt;
    end

    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|hw_evt) |=> (($past(hw_evt) & flags) == $past(hw_evt)));

    a_r2_no_hw_clear: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((flags & $past(flags)) == $past(flags)));

    a_r3_unmasked_kept: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((flags ^ $past(flags)) & ~$past(wr_mask) & ~$past(hw_evt)) == '0));

endmodule

// File: rtl/shv_vec_sampler.sv
module shv_vec_sampler
    import shv_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t flags,
    output vec_set_t  pend_q
);

    vec_set_t pend_c;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        localparam flag_vec_t GMASK = group_mask(v);
        assign pend_c[v] = |(flags & GMASK);
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_c;
    end

    a_r5_sample_or: assert property (@(posedge clk) disable iff (rst)
        (flags == '0) |=> (pend_q == '0));

endmodule

// File: rtl/shv_vec_arbiter.sv
module shv_vec_arbiter
    import shv_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  vec_set_t pend,
    input  vec_set_t vec_en,
    input  logic     glb_en,
    input  logic     reti_ack,
    output call_t    call_q
);

    vec_set_t  elig;
    vec_set_t  grant;
    vec_addr_t grant_addr;
    logic      in_service;

    always_comb begin
        elig  = pend & vec_en & {NUM_VEC{glb_en}};
        grant = elig & (~elig + 1'b1);
        grant_addr = '0;
        for (int unsigned v = 0; v < NUM_VEC; v++)
            if (grant[v]) grant_addr = vec_addr(v);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            call_q     <= '0;
            in_service <= 1'b0;
        end else begin
            call_q.valid <= (|grant) && !in_service;
            if ((|grant) && !in_service) begin
                call_q.addr <= grant_addr;
                in_service  <= 1'b1;
            end else if (reti_ack) begin
                in_service  <= 1'b0;
            end
        end
    end

    a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
        call_q.valid |=> !call_q.valid);

    a_r10_hold_off: assert property (@(posedge clk) disable iff (rst)
        (in_service && !reti_ack) |=> !call_q.valid);

    a_r7_global_gate: assert property (@(posedge clk) disable iff (rst)
        !glb_en |=> !call_q.valid);

endmodule

// File: rtl/shv_irq_ctrl.sv
module shv_irq_ctrl
    import shv_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_FLAG-1:0] hw_evt,
    input  logic                sw_wr_en,
    input  logic [NUM_FLAG-1:0] sw_wr_mask,
    input  logic [NUM_FLAG-1:0] sw_wr_data,
    input  logic [NUM_VEC-1:0]  vec_en,
    input  logic                glb_en,
    input  logic                reti_ack,
    output logic [NUM_FLAG-1:0] flags_q,
    output logic                call_req,
    output logic [ADDR_W-1:0]   call_addr
);

    flag_vec_t flags;
    vec_set_t  pend;
    call_t     call;

    shv_flag_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .hw_evt  (hw_evt),
        .wr_en   (sw_wr_en),
        .wr_mask (sw_wr_mask),
        .wr_data (sw_wr_data),
        .flags   (flags)
    );

    shv_vec_sampler u_samp (
        .clk    (clk),
        .rst    (rst),
        .flags  (flags),
        .pend_q (pend)
    );

    shv_vec_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .pend     (pend),
        .vec_en   (vec_en),
        .glb_en   (glb_en),
        .reti_ack (reti_ack),
        .call_q   (call)
    );

    assign flags_q   = flags;
    assign call_req  = call.valid;
    assign call_addr = call.addr;

    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        call_req |-> ($past(pend) != '0));

endmodule

// File: tb/test_shv_irq_ctrl.sv
module test_shv_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [8:0]  hw_evt;
    logic        sw_wr_en;
    logic [8:0]  sw_wr_mask;
    logic [8:0]  sw_wr_data;
    logic [4:0]  vec_en;
    logic        glb_en;
    logic        reti_ack;
    logic [8:0]  flags_q;
    logic        call_req;
    logic [15:0] call_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    shv_irq_ctrl i_shv_irq_ctrl (
        .clk(clk), .rst(rst), .hw_evt(hw_evt), .sw_wr_en(sw_wr_en),
        .sw_wr_mask(sw_wr_mask), .sw_wr_data(sw_wr_data), .vec_en(vec_en),
        .glb_en(glb_en), .reti_ack(reti_ack), .flags_q(flags_q),
        .call_req(call_req), .call_addr(call_addr)
    );

    int grp_base [5] = '{0, 2, 3, 6, 8};
    int grp_size [5] = '{2, 1, 3, 2, 1};

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] flags_for(int p, int sel);
        logic [8:0] f = '0;
        for (int v = 0; v < 5; v++)
            if (p[v]) f[grp_base[v] + (sel % grp_size[v])] = 1'b1;
        return f;
    endfunction

    task automatic tick;
        @(negedge clk);
    endtask

    // clear all flags, let sampling settle, then release the in-service hold
    task automatic cleanup;
        sw_wr_en = 1; sw_wr_mask = '1; sw_wr_data = '0;
        tick;
        sw_wr_en = 0;
        tick;
        reti_ack = 1;
        tick;
        reti_ack = 0;
        tick;
    endtask

    task automatic trial(int p, int en, bit g, int sel);
        logic [8:0] fv;
        int elig;
        int exp_v;
        fv = flags_for(p, sel);
        elig = g ? (p & en) : 0;
        exp_v = -1;
        for (int v = 4; v >= 0; v--) if (elig[v]) exp_v = v;
        vec_en = en[4:0]; glb_en = g;
        sw_wr_en = 1; sw_wr_mask = '1; sw_wr_data = fv;
        tick;                                   // after edge A
        sw_wr_en = 0;
        chk(flags_q == fv, "R3 R5 write", flags_q, fv);
        tick;                                   // after edge A+1
        chk(call_req == 0, "R6 early", call_req, 0);
        tick;                                   // after edge A+2
        chk(call_req == (exp_v >= 0), "R6 R7 R8 call", call_req, exp_v >= 0);
        if (exp_v >= 0)
            chk(call_addr == 16'h2B + 8 * exp_v, "R8 R9 addr", call_addr, 16'h2B + 8 * exp_v);
        tick;                                   // after edge A+3
        chk(call_req == 0, "R9 R10 strobe", call_req, 0);
        chk(flags_q == fv, "R2 R7 kept", flags_q, fv);
        cleanup;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int sel = 0;
        rst = 1; hw_evt = '0; sw_wr_en = 0; sw_wr_mask = '0; sw_wr_data = '0;
        vec_en = '1; glb_en = 1; reti_ack = 0;
        hw_evt = 9'h1FF;
        tick; tick;
        chk(flags_q == 0, "R1 flags in reset", flags_q, 0);
        chk(call_req == 0, "R1 call in reset", call_req, 0);
        hw_evt = '0;
        tick;
        rst = 0;
        tick;
        chk(flags_q == 0, "R1 flags after reset", flags_q, 0);
        chk(call_req == 0, "R1 call after reset", call_req, 0);

        // sweep pending patterns against enables, global enable on
        for (int p = 0; p < 32; p++)
            for (int en = 0; en < 32; en++) begin
                trial(p, en, 1'b1, sel);
                sel++;
            end
        // global enable off
        for (int p = 0; p < 32; p++) begin
            trial(p, 31, 1'b0, sel);
            sel++;
        end

        // R6: hardware event on flag 8 -> vector 4
        vec_en = '1; glb_en = 1;
        hw_evt = 9'h100;
        tick;
        hw_evt = '0;
        chk(flags_q == 9'h100, "R2 hw set", flags_q, 9'h100);
        tick;
        chk(call_req == 0, "R6 hw early", call_req, 0);
        tick;
        chk(call_req == 1 && call_addr == 16'h004B, "R6 hw call", call_addr, 16'h004B);
        cleanup;

        // R4: hardware set beats software clear; flag 4 already set
        sw_wr_en = 1; sw_wr_mask = 9'h010; sw_wr_data = 9'h010; glb_en = 0;
        tick;
        hw_evt = 9'h010; sw_wr_data = 9'h000;
        tick;
        hw_evt = '0; sw_wr_en = 0;
        chk(flags_q[4] == 1, "R4 set wins", flags_q[4], 1);
        // R3: masked write touches only bit 4, other bits untouched
        sw_wr_en = 1; sw_wr_mask = 9'h010; sw_wr_data = 9'h1EF;
        tick;
        sw_wr_en = 0;
        chk(flags_q == 9'h000, "R3 masked clear", flags_q, 0);

        // R11: cancel while disabled, then enable
        hw_evt = 9'h008;
        tick;
        hw_evt = '0;
        tick; tick;
        chk(flags_q == 9'h008 && call_req == 0, "R7 disabled pending", flags_q, 9'h008);
        sw_wr_en = 1; sw_wr_mask = 9'h008; sw_wr_data = '0;
        tick;
        sw_wr_en = 0;
        tick; tick;
        glb_en = 1;
        for (int i = 0; i < 4; i++) begin
            tick;
            chk(call_req == 0, "R11 cancelled", call_req, 0);
        end
        cleanup;

        // R10: hold until return acknowledge, flags survive the call
        sw_wr_en = 1; sw_wr_mask = '1; sw_wr_data = 9'h044;
        tick;
        sw_wr_en = 0;
        tick; tick;
        chk(call_req == 1 && call_addr == 16'h0033, "R10 first call", call_addr, 16'h0033);
        for (int i = 0; i < 4; i++) begin
            tick;
            chk(call_req == 0, "R10 held off", call_req, 0);
        end
        reti_ack = 1;
        tick;                                   // after edge b
        reti_ack = 0;
        chk(call_req == 0, "R10 at ack", call_req, 0);
        tick;                                   // after edge b+1
        chk(call_req == 1 && call_addr == 16'h0033, "R10 R2 recall", call_addr, 16'h0033);
        chk(flags_q == 9'h044, "R2 flags after call", flags_q, 9'h044);
        cleanup;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule